// File: doc/BRIEF.md
# Full-Bridge Ramp Oscillator and Deadtime Sequencer

This block drives the four gate commands of a full bridge, two low-side and two high-side, from one synchronous clock. A digital up/down counter does the job of a timing capacitor. It climbs by a configurable step until it reaches an upper threshold, and then it falls by the same step to a lower threshold. Each reversal switches from one bridge diagonal to the other. One diagonal is the first low side with the second high side. The other is the second low side with the first high side. A programmable all-low gap separates the two diagonals.

The sequencer also handles the protection states. While supply-good is low, every output is off. Right after start-up, and while the ramp-hold input is held, both low sides are driven on so that the high-side bootstrap supplies can charge. A shutdown input passes through a two-flop synchronizer and then sets a fault latch. Only a fall of supply-good clears that latch.

States and transitions:
- UVLO goes to PRECHG when supply-good rises.
- PRECHG goes to DEAD_A when the ramp reaches the lower threshold.
- DEAD_A goes to DIAG_A when the gap has elapsed.
- DEAD_A or DIAG_A goes to DEAD_B when the ramp reaches the upper threshold.
- DEAD_B goes to DIAG_B when the gap has elapsed.
- DEAD_B or DIAG_B goes to DEAD_A when the ramp reaches the lower threshold.
- Any running state goes to HOLD while the hold input is asserted. HOLD goes back to PRECHG on release.
- Any powered state goes to FAULT when the synchronized shutdown is high.
- Every state goes to UVLO when supply-good falls.

Priority runs from supply-good, to fault, to hold, to the normal sequence.

Top module: `bridge_osc_seq`

## Requirements
- R1: One cycle after supply_ok is sampled low, all four outputs are low and ramp reads 0, and they stay that way while supply_ok stays low.
- R2: In the first cycle after supply_ok rises, lo1 and lo2 are high, hi1 and hi2 are low, and ramp is 0. The ramp then rises by cfg_step each cycle. This precharge pattern lasts cfg_lo/cfg_step+1 cycles.
- R3: After precharge, an all-low gap is followed by diagonal A: lo1 and hi2 high, lo2 and hi1 low. During diagonal A the ramp rises by cfg_step per cycle.
- R4: When the ramp reaches cfg_hi, diagonal A ends, the ramp reverses, and after the gap diagonal B follows: lo2 and hi1 high, lo1 and hi2 low. During diagonal B the ramp falls by cfg_step per cycle.
- R5: When the falling ramp reaches cfg_lo, diagonal B ends, the ramp reverses, and after the gap diagonal A follows again, repeating without end.
- R6: When cfg_step divides both thresholds, each steady half-cycle (gap plus diagonal) lasts (cfg_hi-cfg_lo)/cfg_step+2 cycles for both diagonals alike.
- R7: Every gap between diagonals lasts cfg_dead+1 cycles with all outputs low, so cfg_dead=0 still gives one idle cycle.
- R8: hi1 is never high in the same cycle as lo1, and hi2 is never high in the same cycle as lo2.
- R9: fault_in is synchronized over two flops. By the third cycle after it is raised, all outputs are low. They stay low after fault_in falls, until supply_ok falls and rises again, which restarts with precharge.
- R10: While hold_in is high, lo1 and lo2 are high and hi1 and hi2 are low, and ramp reads 0 from the second cycle on. After release, precharge restarts with ramp at 0.
- R11: In the fault state, asserting hold_in has no effect: all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Synchronized supply-good with hysteresis already applied |
| fault_in | input | 1 | Asynchronous shutdown request, latched |
| hold_in | input | 1 | Synchronous ramp-hold, not latched |
| cfg_lo | input | RAMP_W | Lower ramp threshold |
| cfg_hi | input | RAMP_W | Upper ramp threshold |
| cfg_step | input | RAMP_W | Ramp increment per cycle |
| cfg_dead | input | DEAD_W | Gap length minus one, in cycles |
| lo1 | output | 1 | Low-side command, leg 1 |
| lo2 | output | 1 | Low-side command, leg 2 |
| hi1 | output | 1 | High-side command, leg 1 |
| hi2 | output | 1 | High-side command, leg 2 |
| ramp | output | RAMP_W | Current ramp value |

## Verification
The bench measures run lengths of each output pattern, so each mistake shows up as a specific wrong count:
- A gap that is off by one, or missing when cfg_dead is zero, gives the wrong gap length.
- A ramp that overshoots on only one side gives unequal half-cycles.
- A precharge that starts from a stale ramp gives a short precharge.

It raises the shutdown input in the middle of a diagonal, then releases it. A latch that clears on release would start oscillating again. It asserts hold while in fault, where a wrong priority would turn the low sides back on. It also applies hold during diagonal B and checks both the restart from zero and the direction of the ramp. A design that kept the old ramp would skip precharge.

// File: rtl/bos_pkg.sv
package bos_pkg;
    typedef enum logic [2:0] {
        ST_UVLO,
        ST_PRECHG,
        ST_DEAD_A,
        ST_DIAG_A,
        ST_DEAD_B,
        ST_DIAG_B,
        ST_HOLD,
        ST_FAULT
    } bos_state_t;

    typedef enum logic [1:0] {
        RM_CLEAR,
        RM_UP,
        RM_DOWN
    } ramp_mode_t;
endpackage

// File: rtl/bos_sync.sv
module bos_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bos_ramp.sv
module bos_ramp
    import bos_pkg::*;
#(
    parameter int RAMP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ramp_mode_t        mode,
    input  logic [RAMP_W-1:0] step,
    output logic [RAMP_W-1:0] value
);
    localparam logic [RAMP_W-1:0] FULL = {RAMP_W{1'b1}};

    logic [RAMP_W:0]   sum;
    logic [RAMP_W-1:0] next_val;

    assign sum = {1'b0, value} + {1'b0, step};

    always_comb begin
        unique case (mode)
            RM_UP:   next_val = sum[RAMP_W] ? FULL : sum[RAMP_W-1:0];
            RM_DOWN: next_val = (value < step) ? '0 : value - step;
            default: next_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value <= '0;
        else        value <= next_val;
    end
endmodule

// File: rtl/bos_dead.sv
module bos_dead #(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DEAD_W-1:0] length,
    output logic              expired
);
    logic [DEAD_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= length;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/bridge_osc_seq.sv
module bridge_osc_seq
    import bos_pkg::*;
#(
    parameter int RAMP_W      = 12,
    parameter int DEAD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              fault_in,
    input  logic              hold_in,
    input  logic [RAMP_W-1:0] cfg_lo,
    input  logic [RAMP_W-1:0] cfg_hi,
    input  logic [RAMP_W-1:0] cfg_step,
    input  logic [DEAD_W-1:0] cfg_dead,
    output logic              lo1,
    output logic              lo2,
    output logic              hi1,
    output logic              hi2,
    output logic [RAMP_W-1:0] ramp
);
    bos_state_t state_q, state_d;
    ramp_mode_t ramp_mode;
    logic       fault_s;
    logic       dead_done;
    logic       dead_load;
    logic       at_hi, at_lo;

    bos_sync #(.STAGES(SYNC_STAGES)) u_fault_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (fault_in),
        .q     (fault_s)
    );

    bos_ramp #(.RAMP_W(RAMP_W)) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (ramp_mode),
        .step  (cfg_step),
        .value (ramp)
    );

    bos_dead #(.DEAD_W(DEAD_W)) u_dead (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (dead_load),
        .length  (cfg_dead),
        .expired (dead_done)
    );

    assign at_hi = (ramp >= cfg_hi);
    assign at_lo = (ramp <= cfg_lo);

    // Next-state selection: supply, then fault, then hold, then sequence.
    always_comb begin
        state_d = state_q;
        if (!supply_ok) begin
            state_d = ST_UVLO;
        end else if (fault_s || state_q == ST_FAULT) begin
            state_d = ST_FAULT;
        end else if (hold_in) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_UVLO:   state_d = ST_PRECHG;
                ST_HOLD:   state_d = ST_PRECHG;
                ST_PRECHG: if (at_lo == 1'b0 || ramp == cfg_lo) begin
                               if (ramp >= cfg_lo) state_d = ST_DEAD_A;
                           end
                ST_DEAD_A: if (at_hi)          state_d = ST_DEAD_B;
                           else if (dead_done) state_d = ST_DIAG_A;
                ST_DIAG_A: if (at_hi)          state_d = ST_DEAD_B;
                ST_DEAD_B: if (at_lo)          state_d = ST_DEAD_A;
                           else if (dead_done) state_d = ST_DIAG_B;
                ST_DIAG_B: if (at_lo)          state_d = ST_DEAD_A;
                ST_FAULT:  state_d = ST_FAULT;
            endcase
        end
    end

    assign dead_load = (state_d != state_q) &&
                       (state_d == ST_DEAD_A || state_d == ST_DEAD_B);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UVLO;
        else        state_q <= state_d;
    end

    // Output and ramp-direction decode from the present state.
    always_comb begin
        lo1       = 1'b0;
        lo2       = 1'b0;
        hi1       = 1'b0;
        hi2       = 1'b0;
        ramp_mode = RM_CLEAR;
        unique case (state_q)
            ST_UVLO:   ramp_mode = RM_CLEAR;
            ST_FAULT:  ramp_mode = RM_CLEAR;
            ST_HOLD: begin
                lo1 = 1'b1;
                lo2 = 1'b1;
            end
            ST_PRECHG: begin
                lo1       = 1'b1;
                lo2       = 1'b1;
                ramp_mode = RM_UP;
            end
            ST_DEAD_A: ramp_mode = RM_UP;
            ST_DIAG_A: begin
                lo1       = 1'b1;
                hi2       = 1'b1;
                ramp_mode = RM_UP;
            end
            ST_DEAD_B: ramp_mode = RM_DOWN;
            ST_DIAG_B: begin
                lo2       = 1'b1;
                hi1       = 1'b1;
                ramp_mode = RM_DOWN;
            end
        endcase
        if (!supply_ok) ramp_mode = RM_CLEAR;
    end
endmodule

// File: rtl/bridge_osc_sva.sv
module bridge_osc_sva
    import bos_pkg::*;
#(
    parameter int RAMP_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_ok,
    input logic              hold_in,
    input logic              fault_s,
    input bos_state_t        state_q,
    input logic              lo1,
    input logic              lo2,
    input logic              hi1,
    input logic              hi2,
    input logic [RAMP_W-1:0] ramp
);
    a_r8_leg1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo1 && hi1));

    a_r8_leg2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo2 && hi2));

    a_r1_uvlo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!lo1 && !lo2 && !hi1 && !hi2 && ramp == '0));

    a_r7_gap_after_a: assert property (@(posedge clk) disable iff (!rst_n)
        (lo1 && hi2) |=> !hi1);

    a_r7_gap_after_b: assert property (@(posedge clk) disable iff (!rst_n)
        (lo2 && hi1) |=> !hi2);

    a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT && supply_ok) |=> state_q == ST_FAULT);

    a_r10_hold_lows: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && hold_in && !fault_s && state_q != ST_FAULT)
        |=> (lo1 && lo2 && !hi1 && !hi2));

    a_r11_fault_over_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT && supply_ok && hold_in) |=> (!lo1 && !lo2));
endmodule

bind bridge_osc_seq bridge_osc_sva #(.RAMP_W(RAMP_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .hold_in   (hold_in),
    .fault_s   (fault_s),
    .state_q   (state_q),
    .lo1       (lo1),
    .lo2       (lo2),
    .hi1       (hi1),
    .hi2       (hi2),
    .ramp      (ramp)
);

// File: tb/test_bridge_osc_seq.sv
module test_bridge_osc_seq;
    localparam int RW = 12;
    localparam int DW = 8;

    localparam logic [2:0] P_LOW = 3'd0;
    localparam logic [2:0] P_PRE = 3'd1;
    localparam logic [2:0] P_A   = 3'd2;
    localparam logic [2:0] P_B   = 3'd3;
    localparam logic [2:0] P_OTH = 3'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_ok = 1'b0;
    logic          fault_in = 1'b0;
    logic          hold_in = 1'b0;
    logic [RW-1:0] cfg_lo = 12'd10;
    logic [RW-1:0] cfg_hi = 12'd20;
    logic [RW-1:0] cfg_step = 12'd1;
    logic [DW-1:0] cfg_dead = 8'd2;
    logic          lo1, lo2, hi1, hi2;
    logic [RW-1:0] ramp;

    int checks = 0;
    int errors = 0;
    int overlaps = 0;

    bridge_osc_seq #(.RAMP_W(RW), .DEAD_W(DW)) i_bridge_osc_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .fault_in  (fault_in),
        .hold_in   (hold_in),
        .cfg_lo    (cfg_lo),
        .cfg_hi    (cfg_hi),
        .cfg_step  (cfg_step),
        .cfg_dead  (cfg_dead),
        .lo1       (lo1),
        .lo2       (lo2),
        .hi1       (hi1),
        .hi2       (hi2),
        .ramp      (ramp)
    );

    always #5 clk = ~clk;

    always @(negedge clk)
        if (rst_n && ((hi1 && lo1) || (hi2 && lo2))) overlaps++;

    function automatic logic [2:0] pat();
        case ({lo1, lo2, hi1, hi2})
            4'b0000: return P_LOW;
            4'b1100: return P_PRE;
            4'b1001: return P_A;
            4'b0110: return P_B;
            default: return P_OTH;
        endcase
    endfunction

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic run_len(input logic [2:0] p, output int n);
        n = 0;
        while (pat() == p && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_for(input logic [2:0] p);
        int k;
        k = 0;
        while (pat() != p && k < 5000) begin
            k++;
            @(negedge clk);
        end
    endtask

    task automatic restart(input int lo, input int hi, input int st, input int dt);
        @(negedge clk);
        supply_ok = 1'b0;
        repeat (2) @(negedge clk);
        cfg_lo   = RW'(lo);
        cfg_hi   = RW'(hi);
        cfg_step = RW'(st);
        cfg_dead = DW'(dt);
        supply_ok = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_reset();
        check("R1 reset outputs", int'({lo1, lo2, hi1, hi2}), 0);
        check("R1 reset ramp", int'(ramp), 0);
    endtask

    // Startup, gaps, half-cycle symmetry and ramp direction.
    task automatic test_cycle(input int lo, input int hi, input int st, input int dt);
        int n, half, r0;
        half = (hi - lo) / st + 2;
        restart(lo, hi, st, dt);
        check("R2 precharge first pattern", int'(pat()), int'(P_PRE));
        check("R2 precharge ramp start", int'(ramp), 0);
        run_len(P_PRE, n);
        check("R2 precharge length", n, lo / st + 1);
        run_len(P_LOW, n);
        check("R7 first gap length", n, dt + 1);
        check("R3 diagonal A follows", int'(pat()), int'(P_A));
        r0 = int'(ramp);
        @(negedge clk);
        check("R3 ramp rising in A", int'(ramp), r0 + st);
        run_len(P_A, n);
        run_len(P_LOW, n);
        check("R7 gap A to B", n, dt + 1);
        check("R4 diagonal B follows", int'(pat()), int'(P_B));
        r0 = int'(ramp);
        @(negedge clk);
        check("R4 ramp falling in B", int'(ramp), r0 - st);
        run_len(P_B, n);
        check("R6 diagonal B length", n + 1, half - (dt + 1));
        run_len(P_LOW, n);
        check("R5 gap B to A", n, dt + 1);
        check("R5 diagonal A repeats", int'(pat()), int'(P_A));
        run_len(P_A, n);
        check("R6 diagonal A length", n, half - (dt + 1));
    endtask

    task automatic test_fault();
        int bad;
        restart(10, 20, 1, 2);
        wait_for(P_A);
        fault_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 fault forces all low", int'({lo1, lo2, hi1, hi2}), 0);
        fault_in = 1'b0;
        bad = 0;
        repeat (40) begin
            @(negedge clk);
            if ({lo1, lo2, hi1, hi2} != 4'b0000) bad++;
        end
        check("R9 fault stays latched", bad, 0);
        hold_in = 1'b1;
        bad = 0;
        repeat (10) begin
            @(negedge clk);
            if ({lo1, lo2, hi1, hi2} != 4'b0000) bad++;
        end
        check("R11 hold ignored in fault", bad, 0);
        hold_in = 1'b0;
        supply_ok = 1'b0;
        @(negedge clk);
        supply_ok = 1'b1;
        @(negedge clk);
        check("R9 restart after supply cycle", int'(pat()), int'(P_PRE));
    endtask

    task automatic test_hold();
        int n, bad;
        restart(10, 20, 1, 2);
        wait_for(P_B);
        hold_in = 1'b1;
        @(negedge clk);
        check("R10 hold lows on", int'(pat()), int'(P_PRE));
        @(negedge clk);
        check("R10 hold ramp zero", int'(ramp), 0);
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (pat() != P_PRE || ramp != '0) bad++;
        end
        check("R10 hold steady", bad, 0);
        hold_in = 1'b0;
        @(negedge clk);
        check("R10 restart ramp zero", int'(ramp), 0);
        run_len(P_PRE, n);
        check("R10 precharge after release", n, 11);
    endtask

    task automatic test_uvlo();
        restart(10, 20, 1, 2);
        wait_for(P_A);
        repeat (3) @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        check("R1 supply drop outputs", int'({lo1, lo2, hi1, hi2}), 0);
        check("R1 supply drop ramp", int'(ramp), 0);
        hold_in = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 hold ignored without supply", int'({lo1, lo2, hi1, hi2}), 0);
        hold_in = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_cycle(10, 20, 1, 2);
        test_cycle(10, 20, 1, 0);
        test_cycle(20, 60, 4, 3);
        test_fault();
        test_hold();
        test_uvlo();
        check("R8 no same-leg overlap", overlaps, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule